// File: doc/BRIEF.md
# Operating Mode Clock and Reset Controller

This block sits at the centre of a chip's system integration logic. It keeps track of which operating mode the chip is in and, from that mode, drives the reset lines for the processor core and the peripherals. It also drives the enables for the core, memory and peripheral clocks, and the run enables for the watchdog, the CAN controller, the PLL and the PWM outputs. The PLL, the flash interface, the watchdog, the PWM unit and the CAN controller are not part of the block. Each one appears only as an enable that the block drives or a request that it receives.

Start-up runs in two phases. First, everything is held in reset for a fixed number of cycles. Then only the core stays in reset while the peripherals run, and this lasts until the flash interface reports that it has finished copying its configuration. After that, the core's wait and stop requests, a debug request, wake events and a software reset request move the controller between its working modes. Configuration bits choose whether the watchdog, the CAN controller and the PWM outputs are halted in each low-power or debug mode. The PLL is never switched off automatically. It follows its software enable bit, so software must clear that bit before it issues a stop request.

All outputs are registered and change only on a clock edge. The outputs in a given cycle always describe the mode reported on the `mode` port in that same cycle.

Top module: `opmode_clkrst_ctrl`

## Requirements
- R1: The `mode` port is encoded as follows: 0 total reset, 1 core-only reset, 2 run, 3 debug, 4 wait, 5 stop. While `por_n` is low, the mode is 0, `core_rst` and `per_rst` are both 1, every clock enable is 1, `wdt_en`, `can_en` and `pwm_en` are 0, and `pll_en` is 1.
- R2: After `por_n` rises, the mode stays at total reset for TR_CYCLES rising edges (8 by default) and becomes core-only reset on the TR_CYCLES-th edge. During total reset, both resets are 1.
- R3: In core-only reset, `core_rst` is 1 and `per_rst` is 0, and the peripheral enables are 1. The controller moves to run on the edge at which `flash_done` is sampled high, and not before.
- R4: In run mode, both resets are 0 and all clock, watchdog, CAN and PWM enables are 1.
- R5: From run or from wait, a sampled `dbg_req` enters debug mode on the next edge. It takes priority over `stop_req`, `wait_req` and `irq_any` sampled in the same cycle. Debug mode lasts while `dbg_req` is high and returns to run on the edge at which it is sampled low.
- R6: In debug mode, all clocks run, `wdt_en` is 0, `can_en` is 1, and `pwm_en` is the inverse of `cfg_pwm_off_dbg`.
- R7: In run mode with no debug request, `stop_req` enters stop and takes priority over `wait_req`, and `wait_req` on its own enters wait. In wait mode, `core_clk_en` and `mem_clk_en` are 0, `per_clk_en` and `can_en` are 1, `wdt_en` is the inverse of `cfg_wdt_off_wait`, and `pwm_en` is the inverse of `cfg_pwm_off_wait`.
- R8: Wait mode is held until `irq_any` is sampled high, and then it returns to run on that edge.
- R9: In stop mode, all three clock enables and `pwm_en` are 0, `wdt_en` is the inverse of `cfg_wdt_off_stop`, and `can_en` is the inverse of `cfg_can_off_stop`.
- R10: `pll_en` is the value of `pll_sw_en` sampled at the previous edge, in every mode. Entering stop does not clear it.
- R11: Stop mode is left for run only on an edge at which `can_wake` or `irq_any` is high. A `dbg_req`, `wait_req` or `stop_req` arriving while in stop has no effect on the mode.
- R12: A sampled `rst_req` returns the controller to total reset from any mode, including total reset itself, and restarts the TR_CYCLES count.
- R13: Configuration inputs take effect on the outputs at the first edge at which they are sampled. The outputs never change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rst_req | input | 1 | Synchronous request to restart from total reset |
| flash_done | input | 1 | Flash interface has finished loading its configuration |
| dbg_req | input | 1 | Debug controller requests core halt |
| wait_req | input | 1 | Core executed a wait instruction |
| stop_req | input | 1 | Core executed a stop instruction |
| can_wake | input | 1 | CAN controller wake event |
| irq_any | input | 1 | Any enabled, non-gated interrupt |
| cfg_wdt_off_wait | input | 1 | Halt the watchdog in wait mode |
| cfg_wdt_off_stop | input | 1 | Halt the watchdog in stop mode |
| cfg_can_off_stop | input | 1 | Halt the CAN controller in stop mode |
| cfg_pwm_off_dbg | input | 1 | Disable PWM outputs in debug mode |
| cfg_pwm_off_wait | input | 1 | Disable PWM outputs in wait mode |
| pll_sw_en | input | 1 | Software PLL enable bit |
| mode | output | 3 | Current operating mode (encoding in R1) |
| core_rst | output | 1 | Core reset, active high |
| per_rst | output | 1 | Peripheral reset, active high |
| core_clk_en | output | 1 | Core clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_en | output | 1 | Watchdog run enable |
| can_en | output | 1 | CAN controller run enable |
| pll_en | output | 1 | PLL power enable |
| pwm_en | output | 1 | PWM output enable |

## Verification
The directed part of the test sends simultaneous requests: debug with stop, wait with stop, and debug with an interrupt while in wait. This separates the priority order from the order in which single requests happen to arrive. It also holds stop mode under debug and wait requests, which shows whether stop listens only to its two wake sources. A second `rst_req` issued part-way through total reset shows whether the count restarts or carries on. A long stretch of pseudo-random inputs then sweeps every configuration bit in every mode, and a behavioural model checks each cycle, which catches any wrong enable or mistimed transition.

// File: rtl/opm_pkg.sv
package opm_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      OPM_TOTAL = 3'd0,
      OPM_CORE  = 3'd1,
      OPM_RUN   = 3'd2,
      OPM_DEBUG = 3'd3,
      OPM_WAIT  = 3'd4,
      OPM_STOP  = 3'd5
   } opm_mode_e;

   typedef struct packed {
      logic wdt_off_wait;
      logic wdt_off_stop;
      logic can_off_stop;
      logic pwm_off_dbg;
      logic pwm_off_wait;
   } opm_cfg_t;

   typedef struct packed {
      logic core_rst;
      logic per_rst;
      logic core_clk;
      logic mem_clk;
      logic per_clk;
      logic wdt;
      logic can;
      logic pll;
      logic pwm;
   } opm_out_t;

   localparam int OUT_W = $bits(opm_out_t);

   localparam opm_out_t OUT_RST_VAL = '{core_rst: 1'b1, per_rst: 1'b1,
                                        core_clk: 1'b1, mem_clk: 1'b1,
                                        per_clk: 1'b1, wdt: 1'b0,
                                        can: 1'b0, pll: 1'b1, pwm: 1'b0};

endpackage

// File: rtl/opm_seq.sv
module opm_seq
   import opm_pkg::*;
#(
   parameter int TR_CYCLES = 8
) (
   input  logic      clk,
   input  logic      por_n,
   input  logic      rst_req,
   input  logic      flash_done,
   input  logic      dbg_req,
   input  logic      wait_req,
   input  logic      stop_req,
   input  logic      can_wake,
   input  logic      irq_any,
   output opm_mode_e mode_q,
   output opm_mode_e mode_d
);

   localparam int CNT_W = $clog2(TR_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TR_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      mode_d = mode_q;
      cnt_d  = cnt_q;
      if (rst_req) begin
         mode_d = OPM_TOTAL;
         cnt_d  = '0;
      end else begin
         unique case (mode_q)
            OPM_TOTAL: begin
               if (cnt_q == CNT_LAST) begin
                  mode_d = OPM_CORE;
                  cnt_d  = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            OPM_CORE: begin
               if (flash_done) mode_d = OPM_RUN;
            end
            OPM_RUN: begin
               if (dbg_req)       mode_d = OPM_DEBUG;
               else if (stop_req) mode_d = OPM_STOP;
               else if (wait_req) mode_d = OPM_WAIT;
            end
            OPM_DEBUG: begin
               if (!dbg_req) mode_d = OPM_RUN;
            end
            OPM_WAIT: begin
               if (dbg_req)      mode_d = OPM_DEBUG;
               else if (irq_any) mode_d = OPM_RUN;
            end
            OPM_STOP: begin
               if (can_wake || irq_any) mode_d = OPM_RUN;
            end
            default: begin
               mode_d = OPM_TOTAL;
               cnt_d  = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode_q <= OPM_TOTAL;
         cnt_q  <= '0;
      end else begin
         mode_q <= mode_d;
         cnt_q  <= cnt_d;
      end
   end

endmodule

// File: rtl/opm_decode.sv
module opm_decode
   import opm_pkg::*;
(
   input  opm_mode_e mode_d,
   input  opm_cfg_t  cfg,
   input  logic      pll_sw_en,
   output opm_out_t  out_d
);

   always_comb begin
      out_d     = '{core_rst: 1'b0, per_rst: 1'b0, core_clk: 1'b1,
                    mem_clk: 1'b1, per_clk: 1'b1, wdt: 1'b1,
                    can: 1'b1, pll: 1'b1, pwm: 1'b1};
      out_d.pll = pll_sw_en;
      unique case (mode_d)
         OPM_TOTAL: begin
            out_d.core_rst = 1'b1;
            out_d.per_rst  = 1'b1;
            out_d.wdt      = 1'b0;
            out_d.can      = 1'b0;
            out_d.pwm      = 1'b0;
         end
         OPM_CORE: begin
            out_d.core_rst = 1'b1;
         end
         OPM_RUN: begin
         end
         OPM_DEBUG: begin
            out_d.wdt = 1'b0;
            out_d.pwm = !cfg.pwm_off_dbg;
         end
         OPM_WAIT: begin
            out_d.core_clk = 1'b0;
            out_d.mem_clk  = 1'b0;
            out_d.wdt      = !cfg.wdt_off_wait;
            out_d.pwm      = !cfg.pwm_off_wait;
         end
         OPM_STOP: begin
            out_d.core_clk = 1'b0;
            out_d.mem_clk  = 1'b0;
            out_d.per_clk  = 1'b0;
            out_d.pwm      = 1'b0;
            out_d.wdt      = !cfg.wdt_off_stop;
            out_d.can      = !cfg.can_off_stop;
         end
         default: begin
            out_d.core_rst = 1'b1;
            out_d.per_rst  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/opm_outreg.sv
module opm_outreg #(
   parameter int           W       = 9,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (RST_VAL[i]) begin : g_set
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) q[i] <= 1'b1;
            else        q[i] <= d[i];
         end
      end else begin : g_clr
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
         end
      end
   end

endmodule

// File: rtl/opmode_clkrst_ctrl.sv
module opmode_clkrst_ctrl
   import opm_pkg::*;
#(
   parameter int TR_CYCLES = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_req,
   input  logic              flash_done,
   input  logic              dbg_req,
   input  logic              wait_req,
   input  logic              stop_req,
   input  logic              can_wake,
   input  logic              irq_any,
   input  logic              cfg_wdt_off_wait,
   input  logic              cfg_wdt_off_stop,
   input  logic              cfg_can_off_stop,
   input  logic              cfg_pwm_off_dbg,
   input  logic              cfg_pwm_off_wait,
   input  logic              pll_sw_en,
   output logic [MODE_W-1:0] mode,
   output logic              core_rst,
   output logic              per_rst,
   output logic              core_clk_en,
   output logic              mem_clk_en,
   output logic              per_clk_en,
   output logic              wdt_en,
   output logic              can_en,
   output logic              pll_en,
   output logic              pwm_en
);

   if (TR_CYCLES < 1) begin : g_bad_tr
      $error("TR_CYCLES must be at least 1");
   end

   opm_mode_e mode_q;
   opm_mode_e mode_d;
   opm_cfg_t  cfg;
   opm_out_t  out_d;
   opm_out_t  out_q;

   assign cfg = '{wdt_off_wait: cfg_wdt_off_wait, wdt_off_stop: cfg_wdt_off_stop,
                  can_off_stop: cfg_can_off_stop, pwm_off_dbg: cfg_pwm_off_dbg,
                  pwm_off_wait: cfg_pwm_off_wait};

   opm_seq #(.TR_CYCLES(TR_CYCLES)) u_seq (
      .clk        (clk),
      .por_n      (por_n),
      .rst_req    (rst_req),
      .flash_done (flash_done),
      .dbg_req    (dbg_req),
      .wait_req   (wait_req),
      .stop_req   (stop_req),
      .can_wake   (can_wake),
      .irq_any    (irq_any),
      .mode_q     (mode_q),
      .mode_d     (mode_d)
   );

   opm_decode u_dec (
      .mode_d    (mode_d),
      .cfg       (cfg),
      .pll_sw_en (pll_sw_en),
      .out_d     (out_d)
   );

   opm_outreg #(.W(OUT_W), .RST_VAL(OUT_RST_VAL)) u_oreg (
      .clk   (clk),
      .por_n (por_n),
      .d     (out_d),
      .q     (out_q)
   );

   assign mode        = mode_q;
   assign core_rst    = out_q.core_rst;
   assign per_rst     = out_q.per_rst;
   assign core_clk_en = out_q.core_clk;
   assign mem_clk_en  = out_q.mem_clk;
   assign per_clk_en  = out_q.per_clk;
   assign wdt_en      = out_q.wdt;
   assign can_en      = out_q.can;
   assign pll_en      = out_q.pll;
   assign pwm_en      = out_q.pwm;

endmodule

// File: rtl/opm_chk.sv
module opm_chk #(
   parameter int TR_CYCLES = 8
) (
   input logic       clk,
   input logic       por_n,
   input logic       rst_req,
   input logic       flash_done,
   input logic       dbg_req,
   input logic       stop_req,
   input logic       can_wake,
   input logic       irq_any,
   input logic       pll_sw_en,
   input logic [2:0] mode,
   input logic       core_rst,
   input logic       per_rst,
   input logic       core_clk_en,
   input logic       mem_clk_en,
   input logic       per_clk_en,
   input logic       wdt_en,
   input logic       pll_en
);

   localparam int TW = $clog2(TR_CYCLES + 1) + 1;
   logic [TW-1:0] tot_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)            tot_cnt <= '0;
      else if (rst_req)      tot_cnt <= '0;
      else if (mode == 3'd0) tot_cnt <= tot_cnt + 1'b1;
      else                   tot_cnt <= '0;
   end

   // R1
   mode_legal_chk: assert property (@(posedge clk) disable iff (!por_n)
      mode <= 3'd5);

   // R2
   total_window_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd0) |-> (tot_cnt < TW'(TR_CYCLES)) && core_rst && per_rst);

   // R3
   core_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd1 && !flash_done && !rst_req) |=> (mode == 3'd1) && core_rst && !per_rst);

   // R5
   dbg_first_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd2 && dbg_req && stop_req && !rst_req) |=> (mode == 3'd3) && !wdt_en);

   // R7
   wait_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd4) |-> !core_clk_en && !mem_clk_en && per_clk_en);

   // R9
   stop_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd5) |-> !core_clk_en && !mem_clk_en && !per_clk_en);

   // R10
   pll_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      ($past(mode) == 3'd2 && mode == 3'd5) |-> (pll_en == $past(pll_sw_en)));

   // R11
   stop_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mode == 3'd5 && !can_wake && !irq_any && !rst_req) |=> (mode == 3'd5));

   // R12
   rst_req_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |=> (mode == 3'd0));

endmodule

bind opmode_clkrst_ctrl opm_chk #(.TR_CYCLES(TR_CYCLES)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .rst_req     (rst_req),
   .flash_done  (flash_done),
   .dbg_req     (dbg_req),
   .stop_req    (stop_req),
   .can_wake    (can_wake),
   .irq_any     (irq_any),
   .pll_sw_en   (pll_sw_en),
   .mode        (mode),
   .core_rst    (core_rst),
   .per_rst     (per_rst),
   .core_clk_en (core_clk_en),
   .mem_clk_en  (mem_clk_en),
   .per_clk_en  (per_clk_en),
   .wdt_en      (wdt_en),
   .pll_en      (pll_en)
);

// File: tb/opmode_clkrst_ctrl_bench.sv
module opmode_clkrst_ctrl_bench;

   localparam int TR = 8;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic rst_req = 0, flash_done = 0, dbg_req = 0, wait_req = 0, stop_req = 0;
   logic can_wake = 0, irq_any = 0;
   logic c_wdt_w = 0, c_wdt_s = 0, c_can_s = 0, c_pwm_d = 0, c_pwm_w = 0;
   logic pll_sw_en = 1'b1;
   logic [2:0] mode;
   logic core_rst, per_rst, core_clk_en, mem_clk_en, per_clk_en;
   logic wdt_en, can_en, pll_en, pwm_en;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   opmode_clkrst_ctrl #(.TR_CYCLES(TR)) u_opmode_clkrst_ctrl (
      .clk(clk), .por_n(por_n), .rst_req(rst_req), .flash_done(flash_done),
      .dbg_req(dbg_req), .wait_req(wait_req), .stop_req(stop_req),
      .can_wake(can_wake), .irq_any(irq_any),
      .cfg_wdt_off_wait(c_wdt_w), .cfg_wdt_off_stop(c_wdt_s),
      .cfg_can_off_stop(c_can_s), .cfg_pwm_off_dbg(c_pwm_d),
      .cfg_pwm_off_wait(c_pwm_w), .pll_sw_en(pll_sw_en),
      .mode(mode), .core_rst(core_rst), .per_rst(per_rst),
      .core_clk_en(core_clk_en), .mem_clk_en(mem_clk_en),
      .per_clk_en(per_clk_en), .wdt_en(wdt_en), .can_en(can_en),
      .pll_en(pll_en), .pwm_en(pwm_en));

   // behavioural reference
   int m_mode = 0;
   int m_cnt = 0;
   logic [8:0] m_out = 9'b111110010;

   function automatic logic [8:0] ref_out(int md, logic pll);
      // order: core_rst per_rst core_clk mem_clk per_clk wdt can pll pwm
      case (md)
         0: return {2'b11, 3'b111, 1'b0, 1'b0, pll, 1'b0};
         1: return {2'b10, 3'b111, 1'b1, 1'b1, pll, 1'b1};
         2: return {2'b00, 3'b111, 1'b1, 1'b1, pll, 1'b1};
         3: return {2'b00, 3'b111, 1'b0, 1'b1, pll, !c_pwm_d};
         4: return {2'b00, 3'b001, !c_wdt_w, 1'b1, pll, !c_pwm_w};
         default: return {2'b00, 3'b000, !c_wdt_s, !c_can_s, pll, 1'b0};
      endcase
   endfunction

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_mode = 0; m_cnt = 0; m_out = 9'b111110010;
      end else begin
         if (rst_req) begin
            m_mode = 0; m_cnt = 0;
         end else if (m_mode == 0) begin
            m_cnt++;
            if (m_cnt == TR) begin m_mode = 1; m_cnt = 0; end
         end else if (m_mode == 1) begin
            if (flash_done) m_mode = 2;
         end else if (m_mode == 2) begin
            if (dbg_req) m_mode = 3;
            else if (stop_req) m_mode = 5;
            else if (wait_req) m_mode = 4;
         end else if (m_mode == 3) begin
            if (!dbg_req) m_mode = 2;
         end else if (m_mode == 4) begin
            if (dbg_req) m_mode = 3;
            else if (irq_any) m_mode = 2;
         end else begin
            if (can_wake || irq_any) m_mode = 2;
         end
         m_out = ref_out(m_mode, pll_sw_en);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string mode_tag(int md);
      case (md)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R6";
         4: return "R7";
         default: return "R9";
      endcase
   endfunction

   // per-cycle comparison against the model (R13: outputs settle at the edge)
   always @(negedge clk) begin
      if (por_n && !finished) begin
         chk("R1 mode", int'(mode), m_mode);
         chk({mode_tag(m_mode), " outputs R13"},
             int'({core_rst, per_rst, core_clk_en, mem_clk_en, per_clk_en,
                   wdt_en, can_en, 1'b0, pwm_en}),
             int'({m_out[8:2], 1'b0, m_out[0]}));
         chk("R10 pll_en", int'(pll_en), int'(m_out[1]));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 20000 && !finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", wd, 20000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      step(3);
      // R1 reset state
      chk("R1 mode in por", int'(mode), 0);
      chk("R1 resets in por", int'({core_rst, per_rst}), 3);
      chk("R1 enables in por",
          int'({core_clk_en, mem_clk_en, per_clk_en, wdt_en, can_en, pll_en, pwm_en}),
          7'b1110010);
      por_n = 1'b1;
      step(TR - 1);
      chk("R2 still total", int'(mode), 0);
      step(1);
      chk("R2 core-only reached", int'(mode), 1);
      chk("R3 core held peripherals free", int'({core_rst, per_rst}), 2);
      step(5);
      chk("R3 waits for flash", int'(mode), 1);
      flash_done = 1; step(1);
      chk("R3 run after flash", int'(mode), 2);
      // R5 debug beats stop
      dbg_req = 1; stop_req = 1; c_pwm_d = 1; step(1);
      chk("R5 debug priority", int'(mode), 3);
      chk("R6 pwm off in debug", int'(pwm_en), 0);
      stop_req = 0; step(2);
      chk("R5 debug held", int'(mode), 3);
      dbg_req = 0; step(1);
      chk("R5 debug exit", int'(mode), 2);
      // R7 stop beats wait
      wait_req = 1; stop_req = 1; c_wdt_s = 1; step(1);
      wait_req = 0; stop_req = 0;
      chk("R7 stop priority", int'(mode), 5);
      chk("R9 wdt off in stop", int'(wdt_en), 0);
      chk("R10 pll kept in stop", int'(pll_en), 1);
      dbg_req = 1; wait_req = 1; step(3);
      chk("R11 stop ignores debug and wait", int'(mode), 5);
      dbg_req = 0; wait_req = 0;
      c_can_s = 1; step(1);
      chk("R9 can off in stop", int'(can_en), 0);
      can_wake = 1; step(1); can_wake = 0;
      chk("R11 can wake", int'(mode), 2);
      // R10 software turns the pll off before stop
      pll_sw_en = 0; step(1);
      chk("R10 pll follows sw", int'(pll_en), 0);
      stop_req = 1; step(1); stop_req = 0; step(1);
      chk("R10 stop with pll off", int'({mode, pll_en}), {3'd5, 1'b0});
      irq_any = 1; step(1); irq_any = 0;
      chk("R11 irq wake", int'(mode), 2);
      pll_sw_en = 1;
      // R8 wait
      wait_req = 1; step(1); wait_req = 0;
      chk("R7 wait entry", int'(mode), 4);
      c_wdt_w = 1; step(1);
      chk("R7 wdt off in wait", int'(wdt_en), 0);
      step(3);
      chk("R8 wait held", int'(mode), 4);
      irq_any = 1; step(1); irq_any = 0;
      chk("R8 irq leaves wait", int'(mode), 2);
      wait_req = 1; step(1); wait_req = 0;
      dbg_req = 1; irq_any = 1; step(1); irq_any = 0;
      chk("R5 debug beats irq in wait", int'(mode), 3);
      dbg_req = 0; step(1);
      // R12 reset request and restart
      rst_req = 1; step(1); rst_req = 0;
      chk("R12 back to total", int'(mode), 0);
      step(3);
      rst_req = 1; step(1); rst_req = 0;
      step(TR - 1);
      chk("R12 count restarted", int'(mode), 0);
      step(1);
      chk("R12 core-only after restart", int'(mode), 1);
      // pseudo-random sweep, checked every cycle by the model
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rst_req    = (lfsr[15:10] == 6'd0);
         flash_done = lfsr[0];
         dbg_req    = lfsr[1] & lfsr[2];
         wait_req   = lfsr[3];
         stop_req   = lfsr[4] & lfsr[5];
         can_wake   = lfsr[6] & lfsr[7] & lfsr[8];
         irq_any    = lfsr[9] & lfsr[7];
         c_wdt_w    = lfsr[11];
         c_wdt_s    = lfsr[12];
         c_can_s    = lfsr[13];
         c_pwm_d    = lfsr[14];
         c_pwm_w    = lfsr[10];
         pll_sw_en  = lfsr[2] | lfsr[5];
         step(1);
      end
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule